// File: doc/BRIEF.md
# Tracking Angle Counter with Resolution Control

This block is the digital tracking stage of an angle-to-digital converter. An external demodulator supplies a signed angle error: the input angle minus the present output angle, counted in LSBs of a 14-bit full circle. The block holds a 14-bit up/down angle register and moves it toward null, one LSB of the selected resolution at a time. Each move is marked by a fixed-length busy pulse.

Two select lines choose 10-, 12- or 14-bit resolution, and the choice may change while the block is running. The select lines are sampled only when a busy pulse ends, so a change of resolution never meets a count. When the resolution gets coarser, the register bits below the new LSB are cleared at that same point. The angle is MSB-weighted: the top bit is worth 180 degrees and each lower bit is worth half of the one above it.

An active-high health output reports a fault by dropping to 0. It drops when the error magnitude is more than 65 LSBs of the selected resolution, or when either loss indicator is raised. It returns to 1 once the error settles and both loss indicators are clear.

Top module: `angle_tracker`

## Requirements
- R1: When idle, a step is taken if the error is at least one step size. The register moves up for a positive error and down for a negative one. Each step produces exactly one busy pulse, so the number of pulses equals the number of steps.
- R2: The busy output starts in the cycle after the step is taken and stays high for exactly BUSY_CYC cycles (default 4). It then stays low for at least one cycle. At most one step is taken per pulse.
- R3: The select encoding {res_a,res_b} is as follows. 00 selects 10 bits, with a step of 16 counts. 01 selects 12 bits, with a step of 4 counts. 1x selects 14 bits, with a step of 1 count.
- R4: The select lines are captured only at the trailing edge of a busy pulse. A change on res_a/res_b with no busy pulse has no effect on the step size.
- R5: At the capture point, the register bits below the new LSB are cleared. A pulse taken at the old resolution is therefore followed by this clearing.
- R6: The angle register wraps modulo 2^14 in both directions.
- R7: health_ok is 0 when |err_in| > 65 × step size, and 1 when |err_in| ≤ 65 × step size and neither loss indicator is set. It updates one cycle after its inputs.
- R8: health_ok is 0 one cycle after los or lor is high, whatever the error.
- R9: After reset, angle_out is 0, busy is 0 and health_ok is 1, and the resolution is 14 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_in | input | 16 | Signed error, input angle minus output angle, in 14-bit counts |
| res_a | input | 1 | Resolution select, high bit |
| res_b | input | 1 | Resolution select, low bit |
| los | input | 1 | Loss-of-signal indicator |
| lor | input | 1 | Loss-of-reference indicator |
| angle_out | output | 14 | Tracked angle, MSB = 180 degrees |
| busy | output | 1 | High for BUSY_CYC cycles after each step |
| health_ok | output | 1 | 1 = healthy, 0 = fault |

## Verification
The assertions assume that err_in is a fresh measurement against the present angle_out. In the idle cycle after a busy pulse, err_in must reflect every step already taken. The stimulus meets this by deriving err_in combinationally from a target angle and the angle_out port, wrapped to a signed 14-bit difference.

The select lines are changed only while busy is low and the loop has settled, so each capture sees a stable value. During the health checks the error is forced to fixed values instead. There the bench compares only the health output and ignores the stepping this causes.

// File: rtl/angle_pkg.sv
package angle_pkg;
  localparam int ANG_W = 14;

  typedef enum logic [1:0] {RES10 = 2'd0, RES12 = 2'd1, RES14 = 2'd2} res_e;

  function automatic res_e res_decode(input logic a, input logic b);
    if (a) return RES14;
    else if (b) return RES12;
    else return RES10;
  endfunction

  function automatic logic [ANG_W-1:0] step_of(input res_e r);
    case (r)
      RES10:   return ANG_W'(1) << 4;
      RES12:   return ANG_W'(1) << 2;
      default: return ANG_W'(1);
    endcase
  endfunction

  function automatic logic [ANG_W-1:0] mask_of(input res_e r);
    return ~(step_of(r) - ANG_W'(1));
  endfunction
endpackage

// File: rtl/res_latch.sv
module res_latch
  import angle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic latch_ev,
  input  logic sel_a,
  input  logic sel_b,
  output res_e res_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= RES14;
    else if (latch_ev) res_q <= res_decode(sel_a, sel_b);
  end

  a_r4_res_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_ev |=> $stable(res_q));
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
  import angle_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int BUSY_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] err,
  input  res_e             res_q,
  output logic             busy,
  output logic             step_up,
  output logic             step_dn,
  output logic             busy_end
);
  localparam int CW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

  logic [CW-1:0]          cnt;
  logic signed [ERR_W:0]  err_x;
  logic signed [ERR_W:0]  stp_x;

  always_comb begin
    err_x   = $signed({err[ERR_W-1], err});
    stp_x   = $signed({{(ERR_W+1-ANG_W){1'b0}}, step_of(res_q)});
    step_up = !busy && (err_x >= stp_x);
    step_dn = !busy && (err_x <= -stp_x);
    busy_end = busy && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (step_up || step_dn) begin
      busy <= 1'b1;
      cnt  <= CW'(BUSY_CYC - 1);
    end else if (busy_end) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end
  end

  a_r1_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));
  a_r1_step_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |=> busy);
  a_r2_gap_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    busy_end |=> !busy);
endmodule

// File: rtl/angle_counter.sv
module angle_counter
  import angle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic [ANG_W-1:0] step_amt,
  input  logic             clr_ev,
  input  logic [ANG_W-1:0] clr_mask,
  output logic [ANG_W-1:0] angle
);
  always_ff @(posedge clk) begin
    if (!rst_n) angle <= '0;
    else if (step_up) angle <= angle + step_amt;
    else if (step_dn) angle <= angle - step_amt;
    else if (clr_ev) angle <= angle & clr_mask;
  end

  a_r1_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up || step_dn || clr_ev) |=> $stable(angle));
endmodule

// File: rtl/health_mon.sv
module health_mon
  import angle_pkg::*;
#(
  parameter int ERR_W  = 16,
  parameter int THRESH = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] err,
  input  res_e             res_q,
  input  logic             los,
  input  logic             lor,
  output logic             health_ok
);
  logic signed [ERR_W:0] err_x;
  logic [ERR_W:0]        mag;
  logic [ERR_W:0]        limit;
  logic                  too_far;

  always_comb begin
    err_x   = $signed({err[ERR_W-1], err});
    mag     = err_x[ERR_W] ? $unsigned(-err_x) : $unsigned(err_x);
    limit   = (ERR_W+1)'(THRESH) * (ERR_W+1)'(step_of(res_q));
    too_far = mag > limit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) health_ok <= 1'b1;
    else health_ok <= !(too_far || los || lor);
  end

  a_r8_loss_forces_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (los || lor) |=> !health_ok);
  a_r7_far_error_faults: assert property (@(posedge clk) disable iff (!rst_n)
    too_far |=> !health_ok);
endmodule

// File: rtl/angle_tracker.sv
module angle_tracker
  import angle_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int BUSY_CYC = 4,
  parameter int THRESH   = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] err_in,
  input  logic             res_a,
  input  logic             res_b,
  input  logic             los,
  input  logic             lor,
  output logic [ANG_W-1:0] angle_out,
  output logic             busy,
  output logic             health_ok
);
  res_e             res_q;
  logic             step_up, step_dn, busy_end;
  logic [ANG_W-1:0] step_amt, new_mask;

  assign step_amt = step_of(res_q);
  assign new_mask = mask_of(res_decode(res_a, res_b));

  res_latch u_res (
    .clk(clk), .rst_n(rst_n), .latch_ev(busy_end),
    .sel_a(res_a), .sel_b(res_b), .res_q(res_q)
  );

  step_ctrl #(.ERR_W(ERR_W), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .err(err_in), .res_q(res_q),
    .busy(busy), .step_up(step_up), .step_dn(step_dn), .busy_end(busy_end)
  );

  angle_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .step_amt(step_amt), .clr_ev(busy_end), .clr_mask(new_mask),
    .angle(angle_out)
  );

  health_mon #(.ERR_W(ERR_W), .THRESH(THRESH)) u_health (
    .clk(clk), .rst_n(rst_n), .err(err_in), .res_q(res_q),
    .los(los), .lor(lor), .health_ok(health_ok)
  );

  a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busy_end |=> ((angle_out & ~mask_of(res_q)) == '0));
endmodule

// File: tb/tb_angle_tracker.sv
module tb_angle_tracker;
  localparam int BUSY = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] err_in;
  logic        res_a = 1, res_b = 0, los = 0, lor = 0;
  logic [13:0] angle_out;
  logic        busy, health_ok;

  logic [13:0] target = 0;
  logic        force_en = 0;
  logic [15:0] force_val = 0;
  logic [13:0] diff;

  int total = 0, fails = 0, pulses = 0, bad_width = 0, width = 0;
  logic busy_d = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign diff   = target - angle_out;
  assign err_in = force_en ? force_val : {{2{diff[13]}}, diff};

  angle_tracker #(.BUSY_CYC(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .res_a(res_a), .res_b(res_b),
    .los(los), .lor(lor), .angle_out(angle_out), .busy(busy), .health_ok(health_ok)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !busy_d) begin pulses++; width = 1; end
      else if (busy) width++;
      if (!busy && busy_d && width != BUSY) bad_width++;
      busy_d = busy;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic settle();
    int low = 0;
    for (int i = 0; i < 20000 && low < BUSY + 3; i++) begin
      @(negedge clk);
      if (busy) low = 0; else low++;
    end
  endtask

  task automatic track(input int tgt, input string tag, input int exp_ang, input int exp_pulses);
    pulses = 0;
    @(negedge clk);
    target = 14'(tgt);
    settle();
    check({tag, " angle"}, int'(angle_out), exp_ang);
    check({tag, " pulses"}, pulses, exp_pulses);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #400000;
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset angle", int'(angle_out), 0);
    check("R9 reset busy", int'(busy), 0);
    check("R9 reset health", int'(health_ok), 1);

    // R1 R9: 14-bit steps of 1 count
    track(5, "R1 up 14-bit", 5, 5);
    // R4 R5 R3: select 01 (12-bit) latched after a 14-bit step: 6 -> cleared to 4, then 8, 12
    res_a = 0; res_b = 1;
    track(13, "R5 coarsen to 12", 12, 3);
    // R3 R5: select 00 (10-bit): one 12-bit step to 16, then steps of 16 to 192
    res_a = 0; res_b = 0;
    track(200, "R3 coarsen to 10", 192, 12);
    // R6 wrap downward through zero in 16-count steps
    track(16368, "R6 wrap down", 16368, 13);
    // R6 wrap upward through zero
    track(32, "R6 wrap up", 32, 3);
    // R4: select 11 (14-bit) with error below the 10-bit step: no pulse, no capture
    res_a = 1; res_b = 1;
    track(35, "R4 no capture", 32, 0);
    // R4 R3: now a 10-bit step to 48, capture 14-bit, then 2 single steps
    track(50, "R4 capture 14", 50, 3);
    check("R2 busy width", bad_width, 0);

    // R1 sweep at 14-bit around the present angle
    for (int d = -20; d <= 20; d++) begin
      int base;
      base = int'(angle_out);
      track((base + d) & 16'h3FFF, "R1 sweep", (base + d) & 16'h3FFF, (d < 0) ? -d : d);
    end
    check("R2 busy width after sweep", bad_width, 0);

    // R7 health thresholds at 14-bit: limit 65
    force_en = 1;
    force_val = 16'd65;
    repeat (2) @(negedge clk);
    check("R7 at limit 14", int'(health_ok), 1);
    force_val = 16'd66;
    repeat (2) @(negedge clk);
    check("R7 over limit 14", int'(health_ok), 0);
    force_val = -16'sd66;
    repeat (2) @(negedge clk);
    check("R7 negative over 14", int'(health_ok), 0);
    force_val = 16'd0;
    repeat (2) @(negedge clk);
    check("R7 recover", int'(health_ok), 1);

    // R7 at 10-bit: limit 65*16 = 1040; a pulse is needed to capture select 00
    res_a = 0; res_b = 0;
    force_val = 16'd1040;
    repeat (BUSY + 4) @(negedge clk);
    check("R7 at limit 10", int'(health_ok), 1);
    force_val = 16'd1041;
    repeat (2) @(negedge clk);
    check("R7 over limit 10", int'(health_ok), 0);
    force_val = -16'sd1040;
    repeat (2) @(negedge clk);
    check("R7 negative at limit 10", int'(health_ok), 1);
    force_val = -16'sd1041;
    repeat (2) @(negedge clk);
    check("R7 negative over 10", int'(health_ok), 0);

    // R8 loss indicators
    force_val = 16'd0;
    los = 1;
    repeat (2) @(negedge clk);
    check("R8 los", int'(health_ok), 0);
    los = 0; lor = 1;
    repeat (2) @(negedge clk);
    check("R8 lor", int'(health_ok), 0);
    lor = 0;
    repeat (2) @(negedge clk);
    check("R8 release", int'(health_ok), 1);

    finish_run();
  end
endmodule